// File: doc/BRIEF.md
# Indirect Host Register Port with Interrupt Control

This block is the host-facing register interface of a network controller. The host sees a small window of word ports. One of them, the index port, holds a register number. A second port, the data port, then reads or writes whichever control/status register that number selects. A third port reaches a separate bank of bus configuration registers through the same index. The window also exposes the station (MAC) address as read-only words, and a port whose write returns every register to its reset state.

Register 0 is the main control word. Its low bits are commands that the datapath receives as one-cycle pulses or as steady run, transmit-on and receive-on levels. Its high bits are event flags that the datapath raises and the host clears by writing 1. The error summary and the interrupt flag are derived in hardware. A per-flag mask in register 3 and a global interrupt enable gate the interrupt output. Registers 1 and 2 give the initialisation block address. Register 4 holds the transmit auto-pad switch and register 15 holds the promiscuous switch. Registers 88 and 89 return a fixed 28-bit identity.

Top module: `nic_hostreg`

## Requirements
- R1: After reset, data-port reads of register 0 return 0x0004 (stop set), the index port reads 0, and irq and run are low.
- R2: Word offset 0x14 stores a 7-bit register index. Data-port accesses at 0x10 reach the register it selects. Registers 1 and 2 hold 16 bits each, read back as written, and form iblk_addr = {reg2, reg1}.
- R3: Writing register 0 with bit 1 (start) set sets start (bit 1), transmitter-on (bit 4) and receiver-on (bit 5), clears stop (bit 2), and drives run, tx_on and rx_on high.
- R4: Writing bit 2 (stop) sets stop and clears start, transmitter-on, receiver-on and init. Stop wins when start is written in the same word. Start and stop are never set together.
- R5: Writing bit 0 (init) sets the init bit, clears stop and gives one init_pulse cycle. The init-done event clears the init bit and sets flag bit 8.
- R6: Writing bit 3 (transmit demand) gives one tx_demand cycle only when stop is clear. Bit 3 always reads 0.
- R7: Datapath events set flags 8 to 14 (init done, tx done, rx done, memory error, missed, collision, babble). Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the flag set.
- R8: Bit 15 reads as the OR of flags 11 to 14. Flags 8 to 10 do not affect it, and writes to bit 15 have no effect.
- R9: Bit 7 and irq equal interrupt enable (bit 6, read/write) AND the OR of flags 8 to 14 not masked by the same bit positions of register 3. A masked flag still reads as set.
- R10: Register 4 bit 11 drives auto_pad and register 15 bit 15 drives promisc. The other bits of these registers read 0.
- R11: Register 88 returns CHIP_ID[15:0] and register 89 returns CHIP_ID[27:16]. Writes to them are ignored, and unimplemented indices read 0.
- R12: Offset 0x1C reads and writes 16-bit bus configuration register [index] when index < NUM_BCR. Beyond that range, writes are dropped and reads return 0.
- R13: Offset 0x00 reads mac_addr[31:0] and offset 0x04 reads mac_addr[47:32] zero-extended. Writes to them change nothing.
- R14: Any write to offset 0x18 returns the index, all registers and the bus configuration bank to their reset values, and soft_rst pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected word port |
| addr | input | 3 | Word port number (byte offset divided by 4) |
| wdata | input | 16 | Write data |
| rdata | output | 32 | Read data of the selected port, combinational |
| mac_addr | input | 48 | Station address shown in the read-only window |
| ev_init_done | input | 1 | Initialisation finished event |
| ev_tx_done | input | 1 | Transmit complete event |
| ev_rx_done | input | 1 | Receive complete event |
| ev_mem_err | input | 1 | Memory error event |
| ev_missed | input | 1 | Missed frame event |
| ev_collision | input | 1 | Collision error event |
| ev_babble | input | 1 | Transmitter timeout event |
| irq | output | 1 | Interrupt request |
| run | output | 1 | Controller started |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| init_pulse | output | 1 | One-cycle initialise command |
| tx_demand | output | 1 | One-cycle transmit poll command |
| soft_rst | output | 1 | One-cycle software reset indication |
| iblk_addr | output | 32 | Initialisation block address |
| auto_pad | output | 1 | Transmit auto-pad enable |
| promisc | output | 1 | Promiscuous mode enable |

## Verification
The hardest case to reach from the ports is a host clear and a datapath event that hit the same flag in the same clock. The bench asserts the receive event during the very cycle it writes a clear word to register 0, then reads the flag back. The stop-over-start collision and a transmit demand issued while stopped are also driven as single writes. For each, the bench checks that the run level stays low and the demand pulse never appears.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    // bit positions of the main control word
    localparam int B_INIT  = 0;
    localparam int B_START = 1;
    localparam int B_STOP  = 2;
    localparam int B_TDMD  = 3;
    localparam int B_IENA  = 6;
    localparam int FLAG_LO = 8;
    localparam int NFLAG   = 7;

    // word ports of the host window
    localparam logic [2:0] P_STA_LO = 3'd0;
    localparam logic [2:0] P_STA_HI = 3'd1;
    localparam logic [2:0] P_DATA   = 3'd4;
    localparam logic [2:0] P_INDEX  = 3'd5;
    localparam logic [2:0] P_SRST   = 3'd6;
    localparam logic [2:0] P_BDATA  = 3'd7;

    typedef struct packed {
        logic             init;
        logic             start;
        logic             stop;
        logic             txon;
        logic             rxon;
        logic             iena;
        logic [NFLAG-1:0] flag;
        logic             init_p;
        logic             tdmd_p;
    } ctl_state_t;

    typedef struct packed {
        logic [15:0]      iadr_lo;
        logic [15:0]      iadr_hi;
        logic [NFLAG-1:0] mask;
        logic             apad;
        logic             prom;
    } cfg_state_t;

endpackage

// File: rtl/hreg_ctl.sv
module hreg_ctl
    import hreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             wr,
    input  logic [3:0]       cmd,
    input  logic             iena_w,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] ev,
    input  logic [NFLAG-1:0] mask,
    output logic [15:0]      rd_val,
    output logic             irq,
    output logic             run,
    output logic             tx_on,
    output logic             rx_on,
    output logic             init_pls,
    output logic             tdmd_pls
);

    localparam ctl_state_t RST_ST = '{stop: 1'b1, default: '0};

    ctl_state_t s_d, s_q;
    logic       intr, errsum;

    always_comb begin
        s_d        = s_q;
        s_d.init_p = 1'b0;
        s_d.tdmd_p = 1'b0;
        if (wr) begin
            s_d.iena = iena_w;
            if (cmd[B_INIT]) begin
                s_d.init   = 1'b1;
                s_d.stop   = 1'b0;
                s_d.init_p = 1'b1;
            end
            if (cmd[B_START]) begin
                s_d.start = 1'b1;
                s_d.stop  = 1'b0;
                s_d.txon  = 1'b1;
                s_d.rxon  = 1'b1;
            end
            if (cmd[B_TDMD] && !s_q.stop && !cmd[B_STOP])
                s_d.tdmd_p = 1'b1;
            if (cmd[B_STOP]) begin
                s_d.stop   = 1'b1;
                s_d.start  = 1'b0;
                s_d.txon   = 1'b0;
                s_d.rxon   = 1'b0;
                s_d.init   = 1'b0;
                s_d.init_p = 1'b0;
            end
            s_d.flag = s_q.flag & ~clr;
        end
        if (ev[0])
            s_d.init = 1'b0;
        s_d.flag = s_d.flag | ev;
        if (srst)
            s_d = RST_ST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_ST;
        else        s_q <= s_d;
    end

    assign intr     = s_q.iena && |(s_q.flag & ~mask);
    assign errsum   = |s_q.flag[6:3];
    assign rd_val   = {errsum, s_q.flag, intr, s_q.iena, s_q.rxon, s_q.txon,
                       1'b0, s_q.stop, s_q.start, s_q.init};
    assign irq      = intr;
    assign run      = s_q.start;
    assign tx_on    = s_q.txon;
    assign rx_on    = s_q.rxon;
    assign init_pls = s_q.init_p;
    assign tdmd_pls = s_q.tdmd_p;

    // R4
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.start && s_q.stop));

    // R4
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && cmd[B_STOP] && !srst |=> s_q.stop && !s_q.txon && !s_q.rxon && !run);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && clr[1] && !ev[1] && !srst |=> !s_q.flag[1]);

    // R7
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev[1] && !srst |=> s_q.flag[1]);

    // R6
    tdmd_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tdmd_pls |-> !$past(s_q.stop));

    // R5
    init_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_pls |-> $past(wr && cmd[B_INIT]));

endmodule

// File: rtl/hreg_cfg.sv
module hreg_cfg
    import hreg_pkg::*;
#(
    parameter int          IDX_W   = 7,
    parameter logic [27:0] CHIP_ID = 28'h5A3C1D7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      wdata,
    output logic [15:0]      rd_val,
    output logic [NFLAG-1:0] mask,
    output logic [31:0]      iblk_addr,
    output logic             auto_pad,
    output logic             promisc
);

    localparam logic [IDX_W-1:0] I_IADR_LO = IDX_W'(1);
    localparam logic [IDX_W-1:0] I_IADR_HI = IDX_W'(2);
    localparam logic [IDX_W-1:0] I_MASK    = IDX_W'(3);
    localparam logic [IDX_W-1:0] I_FEAT    = IDX_W'(4);
    localparam logic [IDX_W-1:0] I_MODE    = IDX_W'(15);
    localparam logic [IDX_W-1:0] I_ID_LO   = IDX_W'(88);
    localparam logic [IDX_W-1:0] I_ID_HI   = IDX_W'(89);

    cfg_state_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr) begin
            case (idx)
                I_IADR_LO: c_d.iadr_lo = wdata;
                I_IADR_HI: c_d.iadr_hi = wdata;
                I_MASK:    c_d.mask    = wdata[FLAG_LO +: NFLAG];
                I_FEAT:    c_d.apad    = wdata[11];
                I_MODE:    c_d.prom    = wdata[15];
                default:   ;
            endcase
        end
        if (srst)
            c_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_comb begin
        case (idx)
            I_IADR_LO: rd_val = c_q.iadr_lo;
            I_IADR_HI: rd_val = c_q.iadr_hi;
            I_MASK:    rd_val = {1'b0, c_q.mask, 8'h00};
            I_FEAT:    rd_val = {4'h0, c_q.apad, 11'h000};
            I_MODE:    rd_val = {c_q.prom, 15'h0000};
            I_ID_LO:   rd_val = CHIP_ID[15:0];
            I_ID_HI:   rd_val = {4'h0, CHIP_ID[27:16]};
            default:   rd_val = 16'h0000;
        endcase
    end

    assign mask      = c_q.mask;
    assign iblk_addr = {c_q.iadr_hi, c_q.iadr_lo};
    assign auto_pad  = c_q.apad;
    assign promisc   = c_q.prom;

    // R2
    iadr_lo_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !srst && idx == I_IADR_LO |=> iblk_addr[15:0] == $past(wdata));

    // R10
    mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !srst && idx == I_MODE |=> promisc == $past(wdata[15]));

endmodule

// File: rtl/hreg_bcr.sv
module hreg_bcr #(
    parameter int NUM_BCR = 32,
    parameter int IDX_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      wdata,
    output logic [15:0]      rd_val
);

    logic [15:0]        bank_d [NUM_BCR];
    logic [15:0]        bank_q [NUM_BCR];
    logic [NUM_BCR-1:0] sel;

    for (genvar g = 0; g < NUM_BCR; g++) begin : g_sel
        assign sel[g] = (idx == IDX_W'(g));

        // R12
        bcr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr && !srst && sel[g] |=> bank_q[g] == $past(wdata));
    end

    always_comb begin
        rd_val = 16'h0000;
        for (int i = 0; i < NUM_BCR; i++) begin
            bank_d[i] = bank_q[i];
            if (srst)
                bank_d[i] = 16'h0000;
            else if (wr && sel[i])
                bank_d[i] = wdata;
            if (sel[i])
                rd_val = rd_val | bank_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BCR; i++) bank_q[i] <= 16'h0000;
        end else begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/nic_hostreg.sv
module nic_hostreg
    import hreg_pkg::*;
#(
    parameter int          IDX_W   = 7,
    parameter int          NUM_BCR = 32,
    parameter logic [27:0] CHIP_ID = 28'h5A3C1D7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [31:0] rdata,
    input  logic [47:0] mac_addr,
    input  logic        ev_init_done,
    input  logic        ev_tx_done,
    input  logic        ev_rx_done,
    input  logic        ev_mem_err,
    input  logic        ev_missed,
    input  logic        ev_collision,
    input  logic        ev_babble,
    output logic        irq,
    output logic        run,
    output logic        tx_on,
    output logic        rx_on,
    output logic        init_pulse,
    output logic        tx_demand,
    output logic        soft_rst,
    output logic [31:0] iblk_addr,
    output logic        auto_pad,
    output logic        promisc
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             srst_p;
    } top_state_t;

    top_state_t t_d, t_q;

    logic             wr_data, wr_bdata, wr_index, wr_srst;
    logic             sel_ctl, wr_ctl, wr_cfg;
    logic [15:0]      ctl_rd, cfg_rd, bcr_rd;
    logic [NFLAG-1:0] ev_vec, mask;

    assign wr_data  = wr_en && addr == P_DATA;
    assign wr_bdata = wr_en && addr == P_BDATA;
    assign wr_index = wr_en && addr == P_INDEX;
    assign wr_srst  = wr_en && addr == P_SRST;
    assign sel_ctl  = t_q.idx == '0;
    assign wr_ctl   = wr_data && sel_ctl;
    assign wr_cfg   = wr_data && !sel_ctl;
    assign ev_vec   = {ev_babble, ev_collision, ev_missed, ev_mem_err,
                       ev_rx_done, ev_tx_done, ev_init_done};

    always_comb begin
        t_d        = t_q;
        t_d.srst_p = wr_srst;
        if (wr_index)
            t_d.idx = wdata[IDX_W-1:0];
        if (wr_srst)
            t_d.idx = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    hreg_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (wr_srst),
        .wr       (wr_ctl),
        .cmd      (wdata[3:0]),
        .iena_w   (wdata[B_IENA]),
        .clr      (wdata[FLAG_LO +: NFLAG]),
        .ev       (ev_vec),
        .mask     (mask),
        .rd_val   (ctl_rd),
        .irq      (irq),
        .run      (run),
        .tx_on    (tx_on),
        .rx_on    (rx_on),
        .init_pls (init_pulse),
        .tdmd_pls (tx_demand)
    );

    hreg_cfg #(.IDX_W(IDX_W), .CHIP_ID(CHIP_ID)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (wr_srst),
        .wr        (wr_cfg),
        .idx       (t_q.idx),
        .wdata     (wdata),
        .rd_val    (cfg_rd),
        .mask      (mask),
        .iblk_addr (iblk_addr),
        .auto_pad  (auto_pad),
        .promisc   (promisc)
    );

    hreg_bcr #(.NUM_BCR(NUM_BCR), .IDX_W(IDX_W)) u_bcr (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst   (wr_srst),
        .wr     (wr_bdata),
        .idx    (t_q.idx),
        .wdata  (wdata),
        .rd_val (bcr_rd)
    );

    always_comb begin
        case (addr)
            P_STA_LO: rdata = mac_addr[31:0];
            P_STA_HI: rdata = {16'h0000, mac_addr[47:32]};
            P_DATA:   rdata = {16'h0000, sel_ctl ? ctl_rd : cfg_rd};
            P_INDEX:  rdata = {{(32-IDX_W){1'b0}}, t_q.idx};
            P_BDATA:  rdata = {16'h0000, bcr_rd};
            default:  rdata = 32'h0000_0000;
        endcase
    end

    assign soft_rst = t_q.srst_p;

    // R14
    srst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_srst |=> soft_rst && t_q.idx == '0 && !run && !irq);

    // R2
    index_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index && !wr_srst |=> t_q.idx == $past(wdata[IDX_W-1:0]));

endmodule

// File: tb/sim_nic_hostreg.sv
module sim_nic_hostreg;

    localparam logic [27:0] ID  = 28'h5A3C1D7;
    localparam logic [47:0] MAC = 48'hA1B2_C3D4_E5F6;
    localparam int NV = 37;

    // {req[3:0], is_read, byte offset[4:0], data/expected[31:0]}
    localparam logic [41:0] VEC [NV] = '{
        {4'd2,  1'b0, 5'h14, 32'h1},          // R2 select reg 1
        {4'd2,  1'b0, 5'h10, 32'hBEEF},
        {4'd2,  1'b0, 5'h14, 32'h2},
        {4'd2,  1'b0, 5'h10, 32'h0012},
        {4'd2,  1'b1, 5'h14, 32'h2},
        {4'd2,  1'b1, 5'h10, 32'h0012},
        {4'd2,  1'b0, 5'h14, 32'h1},
        {4'd2,  1'b1, 5'h10, 32'hBEEF},
        {4'd11, 1'b0, 5'h14, 32'd88},         // R11 identity
        {4'd11, 1'b1, 5'h10, 32'hC1D7},
        {4'd11, 1'b0, 5'h10, 32'hFFFF},
        {4'd11, 1'b1, 5'h10, 32'hC1D7},
        {4'd11, 1'b0, 5'h14, 32'd89},
        {4'd11, 1'b1, 5'h10, 32'h05A3},
        {4'd11, 1'b0, 5'h14, 32'd50},
        {4'd11, 1'b0, 5'h10, 32'h1111},
        {4'd11, 1'b1, 5'h10, 32'h0},
        {4'd12, 1'b0, 5'h14, 32'd5},          // R12 config bank
        {4'd12, 1'b0, 5'h1C, 32'h1234},
        {4'd12, 1'b1, 5'h1C, 32'h1234},
        {4'd12, 1'b0, 5'h14, 32'd40},
        {4'd12, 1'b0, 5'h1C, 32'h5555},
        {4'd12, 1'b1, 5'h1C, 32'h0},
        {4'd12, 1'b0, 5'h14, 32'd5},
        {4'd12, 1'b1, 5'h1C, 32'h1234},
        {4'd13, 1'b1, 5'h00, 32'hC3D4E5F6},   // R13 station window
        {4'd13, 1'b0, 5'h00, 32'h0},
        {4'd13, 1'b1, 5'h00, 32'hC3D4E5F6},
        {4'd13, 1'b1, 5'h04, 32'h0000A1B2},
        {4'd10, 1'b0, 5'h14, 32'd4},          // R10 feature switches
        {4'd10, 1'b0, 5'h10, 32'hFFFF},
        {4'd10, 1'b1, 5'h10, 32'h0800},
        {4'd10, 1'b0, 5'h14, 32'd15},
        {4'd10, 1'b0, 5'h10, 32'hFFFF},
        {4'd10, 1'b1, 5'h10, 32'h8000},
        {4'd10, 1'b0, 5'h14, 32'd0},
        {4'd10, 1'b1, 5'h10, 32'h0004}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [31:0] rdata;
    logic [6:0]  ev = '0;
    logic        irq, run, tx_on, rx_on, init_pulse, tx_demand, soft_rst;
    logic        auto_pad, promisc;
    logic [31:0] iblk_addr;
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    nic_hostreg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .mac_addr(MAC),
        .ev_init_done(ev[0]), .ev_tx_done(ev[1]), .ev_rx_done(ev[2]),
        .ev_mem_err(ev[3]), .ev_missed(ev[4]), .ev_collision(ev[5]),
        .ev_babble(ev[6]),
        .irq(irq), .run(run), .tx_on(tx_on), .rx_on(rx_on),
        .init_pulse(init_pulse), .tx_demand(tx_demand), .soft_rst(soft_rst),
        .iblk_addr(iblk_addr), .auto_pad(auto_pad), .promisc(promisc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a[4:2]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a[4:2];
        #2;
        chk(req, rdata, exp);
    endtask

    task automatic pulse_ev(input int b);
        @(negedge clk);
        ev[b] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1", 5'h10, 32'h0004);
        rd("R1", 5'h14, 32'h0);
        chk("R1", {31'b0, irq}, 32'h0);
        chk("R1", {31'b0, run}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][37])
                rd($sformatf("R%0d", VEC[i][41:38]), VEC[i][36:32], VEC[i][31:0]);
            else
                wr(VEC[i][36:32], VEC[i][15:0]);
        end
        chk("R2", iblk_addr, 32'h0012_BEEF);
        chk("R10", {31'b0, auto_pad}, 32'h1);
        chk("R10", {31'b0, promisc}, 32'h1);

        // R3 start with interrupt enable
        wr(5'h10, 16'h0042);
        rd("R3", 5'h10, 32'h0072);
        chk("R3", {29'b0, run, tx_on, rx_on}, 32'h7);
        chk("R9", {31'b0, irq}, 32'h0);

        // R7 / R9 tx event raises flag and irq
        pulse_ev(1);
        rd("R7", 5'h10, 32'h02F2);
        chk("R9", {31'b0, irq}, 32'h1);
        wr(5'h14, 16'd3);
        wr(5'h10, 16'h0200);
        chk("R9", {31'b0, irq}, 32'h0);
        wr(5'h14, 16'd0);
        rd("R9", 5'h10, 32'h0272);
        wr(5'h14, 16'd3);
        wr(5'h10, 16'h0000);
        wr(5'h14, 16'd0);
        chk("R9", {31'b0, irq}, 32'h1);

        // R7 write-one-to-clear
        wr(5'h10, 16'h0040);
        rd("R7", 5'h10, 32'h02F2);
        wr(5'h10, 16'h0240);
        rd("R7", 5'h10, 32'h0072);
        chk("R9", {31'b0, irq}, 32'h0);

        // R7 event collides with clear of the same flag
        @(negedge clk);
        addr = 3'd4; wdata = 16'h0440; wr_en = 1'b1; ev[2] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        rd("R7", 5'h10, 32'h04F2);
        wr(5'h10, 16'h0440);
        rd("R7", 5'h10, 32'h0072);

        // R8 error summary
        pulse_ev(6);
        rd("R8", 5'h10, 32'hC0F2);
        wr(5'h10, 16'h8040);
        rd("R8", 5'h10, 32'hC0F2);
        wr(5'h10, 16'h4040);
        rd("R8", 5'h10, 32'h0072);
        pulse_ev(0);
        rd("R8", 5'h10, 32'h01F2);
        wr(5'h10, 16'h0140);

        // R6 transmit demand while running
        @(negedge clk);
        addr = 3'd4; wdata = 16'h0048; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6", {31'b0, tx_demand}, 32'h1);
        @(negedge clk);
        chk("R6", {31'b0, tx_demand}, 32'h0);
        rd("R6", 5'h10, 32'h0072);

        // R4 stop wins over start
        wr(5'h10, 16'h0046);
        rd("R4", 5'h10, 32'h0044);
        chk("R4", {29'b0, run, tx_on, rx_on}, 32'h0);

        // R6 demand ignored while stopped
        @(negedge clk);
        addr = 3'd4; wdata = 16'h0048; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6", {31'b0, tx_demand}, 32'h0);

        // R5 init command and completion
        @(negedge clk);
        addr = 3'd4; wdata = 16'h0041; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R5", {31'b0, init_pulse}, 32'h1);
        rd("R5", 5'h10, 32'h0041);
        chk("R5", {31'b0, init_pulse}, 32'h0);
        pulse_ev(0);
        rd("R5", 5'h10, 32'h01C0);
        chk("R5", {31'b0, irq}, 32'h1);

        // R14 software reset
        wr(5'h14, 16'd5);
        @(negedge clk);
        addr = 3'd6; wdata = 16'h0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R14", {31'b0, soft_rst}, 32'h1);
        rd("R14", 5'h14, 32'h0);
        rd("R14", 5'h10, 32'h0004);
        chk("R14", {31'b0, irq}, 32'h0);
        chk("R14", iblk_addr, 32'h0);
        wr(5'h14, 16'd5);
        rd("R14", 5'h1C, 32'h0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule